// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

The controller watches the pins of several GPIO ports and converts selected edges into CPU interrupts. There are sixteen interrupt lines, and line n always observes pin n. A 3-bit selector for each line chooses which port supplies that pin. All watched pins pass through a multi-flop synchronizer. After synchronization, each line compares its current sample with its previous sample to find rising and falling edges.

A detected edge whose direction is enabled for that line sets the line's flag bit. A per-line enable mask decides whether a flagged line counts as pending. Pending lines with even numbers drive one interrupt output, and pending lines with odd numbers drive the other. Software configures the block and services flags through a simple word-addressed register bus. A read returns its data combinationally in the same cycle as the request. A write takes effect at the next clock edge.

Top module: `gpio_eirq_top`

## Requirements
- R1: The registers sit at these byte offsets: 0x00 low select, 0x04 high select, 0x08 rising enable, 0x0C falling enable, 0x10 interrupt enable, 0x14 flags, 0x18 flag clear. After reset every register reads 0 and both interrupt outputs are low.
- R2: The select field of line n occupies bits [4(n mod 8)+2 : 4(n mod 8)]. Lines 0 to 7 use the register at 0x00 and lines 8 to 15 use the register at 0x04. Bit 4(n mod 8)+3 always reads 0. An unmapped offset such as 0x1C reads 0.
- R3: Line n watches gpio_i[16*p+n], where p is the line's selected port. A select value of NUM_PORTS or higher feeds a constant 0, so that line never sees an edge.
- R4: With rising enable bit n set, a 0-to-1 change on the watched pin sets flag bit n. The flag first reads 1 after the third rising clock edge following the pin change, and still reads 0 after the second.
- R5: With falling enable bit n set, a 1-to-0 change sets flag bit n. With both enable bits set, either direction sets it. A change in a direction that is not enabled leaves the flag at 0.
- R6: A flag bit is set by a qualifying edge even when its interrupt enable bit is 0. That flag reaches an interrupt output only while its enable bit is 1.
- R7: Writing 1 to bit n at 0x18 clears flag bit n, and writing 0 leaves it unchanged. Offset 0x18 always reads 0. Writes to 0x14 are ignored.
- R8: When a flag-clear write and a new qualifying edge for the same line fall in the same cycle, the flag ends up set.
- R9: irq_even_o is the OR of (flags AND enables) over mask 0x5555. irq_odd_o is the same OR over mask 0xAAAA.
- R10: Writing a new port select to a line does not set that line's flag, even when the old pin and the new pin differ in level. After the write, the line detects edges on the new pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address; only word-aligned addresses decode |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| gpio_i | input | 16*NUM_PORTS | Port pins; port p, pin n at bit 16p+n |
| irq_even_o | output | 1 | Interrupt for pending even lines |
| irq_odd_o | output | 1 | Interrupt for pending odd lines |

## Verification
The bench builds the block with NUM_PORTS=5 and SYNC_STAGES=2. This puts the top port at bit 64+n of gpio_i. It also leaves select values 5, 6 and 7 unmapped, so the bench can confirm that those selectors feed a constant 0. With two synchronizer stages the edge-to-flag latency is three clock edges. The bench uses that fixed latency to land a clear write on exactly the cycle of a new edge, and to sample the flag one cycle before and at the cycle it is expected to set.

// File: rtl/gpio_eirq_pkg.sv
package gpio_eirq_pkg;
  localparam int LINES         = 16;
  localparam int SEL_W         = 3;
  localparam int SLOT_W        = 4;
  localparam int LINES_PER_SEL = 8;
  localparam int DATA_W        = 32;
  localparam int IDX_W         = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_SEL_LO = 3'd0,
    IDX_SEL_HI = 3'd1,
    IDX_RISE   = 3'd2,
    IDX_FALL   = 3'd3,
    IDX_IEN    = 3'd4,
    IDX_FLAG   = 3'd5,
    IDX_CLR    = 3'd6
  } reg_idx_e;

  function automatic logic [LINES-1:0] parity_mask(input logic odd);
    logic [LINES-1:0] m;
    for (int i = 0; i < LINES; i++) m[i] = ((i % 2) == 1) == odd;
    return m;
  endfunction
endpackage

// File: rtl/gpio_eirq_sync.sv
module gpio_eirq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_eirq_regs.sv
module gpio_eirq_regs
  import gpio_eirq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  input  logic [LINES-1:0]            flag_i,
  output logic [LINES-1:0][SEL_W-1:0] sel_o,
  output logic [LINES-1:0]            sel_wr_o,
  output logic [LINES-1:0][SEL_W-1:0] sel_wdata_o,
  output logic [LINES-1:0]            rise_o,
  output logic [LINES-1:0]            fall_o,
  output logic [LINES-1:0]            ien_o,
  output logic [LINES-1:0]            clr_o
);
  localparam int BASE_LSB = 2;
  localparam int TOP_LSB  = BASE_LSB + IDX_W;

  logic             upper_ok, aligned, hit, wr, rd;
  logic [IDX_W-1:0] idx;
  logic             unused_wdata;

  logic [LINES-1:0][SEL_W-1:0] sel_q;
  logic [LINES-1:0]            rise_q, fall_q, ien_q;

  assign idx     = addr_i[TOP_LSB-1:BASE_LSB];
  assign aligned = addr_i[BASE_LSB-1:0] == '0;

  generate
    if (ADDR_W > TOP_LSB) begin : g_upper
      assign upper_ok = addr_i[ADDR_W-1:TOP_LSB] == '0;
    end else begin : g_noupper
      assign upper_ok = 1'b1;
    end
  endgenerate

  assign hit          = req_i && upper_ok && aligned;
  assign wr           = hit && we_i;
  assign rd           = hit && !we_i;
  assign unused_wdata = ^wdata_i;

  // per-line select slots, low register for lines 0..7, high for 8..15
  generate
    for (genvar n = 0; n < LINES; n++) begin : g_sel
      localparam int       LSB    = SLOT_W * (n % LINES_PER_SEL);
      localparam reg_idx_e SEL_IX = (n < LINES_PER_SEL) ? IDX_SEL_LO : IDX_SEL_HI;

      assign sel_wr_o[n]    = wr && (idx == SEL_IX);
      assign sel_wdata_o[n] = wdata_i[LSB +: SEL_W];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          sel_q[n] <= '0;
        else if (sel_wr_o[n]) sel_q[n] <= sel_wdata_o[n];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= '0;
      fall_q <= '0;
      ien_q  <= '0;
    end else if (wr) begin
      case (idx)
        IDX_RISE: rise_q <= wdata_i[LINES-1:0];
        IDX_FALL: fall_q <= wdata_i[LINES-1:0];
        IDX_IEN:  ien_q  <= wdata_i[LINES-1:0];
        default:  ;
      endcase
    end
  end

  assign clr_o = (wr && idx == IDX_CLR) ? wdata_i[LINES-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (idx)
        IDX_SEL_LO:
          for (int k = 0; k < LINES_PER_SEL; k++) rdata_o[SLOT_W*k +: SEL_W] = sel_q[k];
        IDX_SEL_HI:
          for (int k = 0; k < LINES_PER_SEL; k++)
            rdata_o[SLOT_W*k +: SEL_W] = sel_q[k+LINES_PER_SEL];
        IDX_RISE: rdata_o[LINES-1:0] = rise_q;
        IDX_FALL: rdata_o[LINES-1:0] = fall_q;
        IDX_IEN:  rdata_o[LINES-1:0] = ien_q;
        IDX_FLAG: rdata_o[LINES-1:0] = flag_i;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign sel_o  = sel_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign ien_o  = ien_q;
endmodule

// File: rtl/gpio_eirq_line.sv
module gpio_eirq_line
  import gpio_eirq_pkg::*;
#(
  parameter int NUM_PORTS = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] pins_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 sel_wr_i,
  input  logic [SEL_W-1:0]     sel_wdata_i,
  input  logic                 rise_en_i,
  input  logic                 fall_en_i,
  input  logic                 clr_i,
  output logic                 set_o,
  output logic                 flag_o
);
  logic cur, nxt_prev, prev_q, flag_q;

  // unmapped select values yield a constant low pin
  function automatic logic pick(input logic [NUM_PORTS-1:0] pins, input logic [SEL_W-1:0] sel);
    logic v;
    v = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) if (sel == SEL_W'(p)) v = pins[p];
    return v;
  endfunction

  assign cur      = pick(pins_i, sel_i);
  // reload history from the newly selected pin so a select change is not an edge
  assign nxt_prev = sel_wr_i ? pick(pins_i, sel_wdata_i) : cur;
  assign set_o    = (rise_en_i && cur && !prev_q) || (fall_en_i && !cur && prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= nxt_prev;
      flag_q <= (flag_q && !clr_i) || set_o;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gpio_eirq_top.sv
module gpio_eirq_top
  import gpio_eirq_pkg::*;
#(
  parameter int NUM_PORTS   = 6,   // at most 2**SEL_W
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  input  logic [LINES*NUM_PORTS-1:0] gpio_i,
  output logic                       irq_even_o,
  output logic                       irq_odd_o
);
  localparam int                 PIN_W     = LINES * NUM_PORTS;
  localparam logic [LINES-1:0]   EVEN_MASK = parity_mask(1'b0);
  localparam logic [LINES-1:0]   ODD_MASK  = parity_mask(1'b1);

  logic [PIN_W-1:0]                pin_s;
  logic [LINES-1:0][SEL_W-1:0]     sel_q, sel_wdata;
  logic [LINES-1:0]                sel_wr, rise_q, fall_q, ien_q, clr_vec, set_vec, flag_q;
  logic [LINES-1:0][NUM_PORTS-1:0] line_pins;

  gpio_eirq_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (gpio_i),
    .q_o    (pin_s)
  );

  gpio_eirq_regs #(
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .flag_i      (flag_q),
    .sel_o       (sel_q),
    .sel_wr_o    (sel_wr),
    .sel_wdata_o (sel_wdata),
    .rise_o      (rise_q),
    .fall_o      (fall_q),
    .ien_o       (ien_q),
    .clr_o       (clr_vec)
  );

  generate
    for (genvar n = 0; n < LINES; n++) begin : g_line
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign line_pins[n][p] = pin_s[p*LINES + n];
      end

      gpio_eirq_line #(
        .NUM_PORTS (NUM_PORTS)
      ) u_line (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pins_i      (line_pins[n]),
        .sel_i       (sel_q[n]),
        .sel_wr_i    (sel_wr[n]),
        .sel_wdata_i (sel_wdata[n]),
        .rise_en_i   (rise_q[n]),
        .fall_en_i   (fall_q[n]),
        .clr_i       (clr_vec[n]),
        .set_o       (set_vec[n]),
        .flag_o      (flag_q[n])
      );
    end
  endgenerate

  assign irq_even_o = |(flag_q & ien_q & EVEN_MASK);
  assign irq_odd_o  = |(flag_q & ien_q & ODD_MASK);
endmodule

// File: rtl/gpio_eirq_chk.sv
module gpio_eirq_chk
  import gpio_eirq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_even_o,
  input logic             irq_odd_o,
  input logic [LINES-1:0] flag_q,
  input logic [LINES-1:0] ien_q,
  input logic [LINES-1:0] rise_q,
  input logic [LINES-1:0] fall_q,
  input logic [LINES-1:0] clr_vec,
  input logic [LINES-1:0] set_vec
);
  localparam logic [LINES-1:0] EVEN_M = parity_mask(1'b0);
  localparam logic [LINES-1:0] ODD_M  = parity_mask(1'b1);

  // R5
  flag_needs_edge_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(rise_q | fall_q)) == '0));

  // R7
  flag_drop_needs_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~flag_q & $past(flag_q) & ~$past(clr_vec)) == '0));

  // R8
  set_beats_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_vec) & ~flag_q) == '0));

  // R9
  even_irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_even_o |-> (|(flag_q & ien_q & EVEN_M)));

  // R9
  odd_irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_odd_o |-> (|(flag_q & ien_q & ODD_M)));

  // R6
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> (!irq_even_o && !irq_odd_o));
endmodule

bind gpio_eirq_top gpio_eirq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_even_o (irq_even_o),
  .irq_odd_o  (irq_odd_o),
  .flag_q     (flag_q),
  .ien_q      (ien_q),
  .rise_q     (rise_q),
  .fall_q     (fall_q),
  .clr_vec    (clr_vec),
  .set_vec    (set_vec)
);

// File: tb/gpio_eirq_top_test.sv
module gpio_eirq_top_test;
  localparam int NP = 5;
  localparam int NL = 16;

  localparam logic [4:0] A_SLO = 5'h00, A_SHI = 5'h04, A_RISE = 5'h08, A_FALL = 5'h0C,
                         A_IEN = 5'h10, A_FLAG = 5'h14, A_CLR = 5'h18, A_NONE = 5'h1C;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic              we_i = 1'b0;
  logic [4:0]        addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [NL*NP-1:0]  gpio_i = '0;
  logic              irq_even_o, irq_odd_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  gpio_eirq_top #(.NUM_PORTS(NP), .SYNC_STAGES(2), .ADDR_W(5)) uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .gpio_i     (gpio_i),
    .irq_even_o (irq_even_o),
    .irq_odd_o  (irq_odd_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic pin(input int p, input int n, input logic v);
    gpio_i[p*NL + n] = v;
  endtask

  task automatic quiesce();
    bus_wr(A_RISE, 0); bus_wr(A_FALL, 0); bus_wr(A_IEN, 0);
    bus_wr(A_CLR, 32'hFFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(A_SLO, d);  chk("R1 sel_lo reset", d, 0);
    bus_rd(A_SHI, d);  chk("R1 sel_hi reset", d, 0);
    bus_rd(A_RISE, d); chk("R1 rise reset", d, 0);
    bus_rd(A_FALL, d); chk("R1 fall reset", d, 0);
    bus_rd(A_IEN, d);  chk("R1 ien reset", d, 0);
    bus_rd(A_FLAG, d); chk("R1 flag reset", d, 0);
    chk("R1 irq reset", {30'd0, irq_odd_o, irq_even_o}, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    bus_wr(A_SLO, 32'hFFFF_FFFF);
    bus_rd(A_SLO, d);  chk("R2 sel_lo slot pad", d, 32'h7777_7777);
    bus_wr(A_SHI, 32'h1234_5670);
    bus_rd(A_SHI, d);  chk("R2 sel_hi fields", d, 32'h1234_5670);
    bus_wr(A_RISE, 32'hFFFF_A5A5);
    bus_rd(A_RISE, d); chk("R1 rise width", d, 32'h0000_A5A5);
    bus_wr(A_RISE, 0);
    bus_rd(A_NONE, d); chk("R2 unmapped", d, 0);
    bus_wr(A_FLAG, 32'hFFFF);
    bus_rd(A_FLAG, d); chk("R7 flag write ignored", d, 0);
    bus_rd(A_CLR, d);  chk("R7 clr reads zero", d, 0);
    bus_wr(A_SLO, 0); bus_wr(A_SHI, 0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    quiesce();
    bus_wr(A_RISE, 32'h0001);
    pin(0, 0, 1'b1);
    tick(2);
    bus_rd(A_FLAG, d); chk("R4 not yet after 2 edges", d, 0);
    tick(1);
    bus_rd(A_FLAG, d); chk("R4 flag after 3 edges", d, 32'h1);
    chk("R6 flag without enable, no irq", {30'd0, irq_odd_o, irq_even_o}, 0);
    bus_wr(A_IEN, 32'h0001);
    chk("R9 even irq line0", {30'd0, irq_odd_o, irq_even_o}, 32'h1);
    bus_wr(A_CLR, 32'h0000);
    bus_rd(A_FLAG, d); chk("R7 write 0 keeps flag", d, 32'h1);
    bus_wr(A_CLR, 32'h0001);
    bus_rd(A_FLAG, d); chk("R7 write 1 clears flag", d, 0);
    chk("R9 irq drops", {30'd0, irq_odd_o, irq_even_o}, 0);
    pin(0, 0, 1'b0); tick(4);
    bus_rd(A_FLAG, d); chk("R5 fall not enabled", d, 0);
  endtask

  task automatic t_fall_both();
    logic [31:0] d;
    quiesce();
    bus_wr(A_FALL, 32'h0008);
    pin(0, 3, 1'b1); tick(4);
    bus_rd(A_FLAG, d); chk("R5 rise ignored on fall-only", d, 0);
    pin(0, 3, 1'b0); tick(4);
    bus_rd(A_FLAG, d); chk("R5 fall sets", d, 32'h0008);
    bus_wr(A_CLR, 32'hFFFF);
    bus_wr(A_RISE, 32'h0020); bus_wr(A_FALL, 32'h0020);
    pin(0, 5, 1'b1); tick(4);
    bus_rd(A_FLAG, d); chk("R5 both: rise", d, 32'h0020);
    bus_wr(A_CLR, 32'h0020);
    pin(0, 5, 1'b0); tick(4);
    bus_rd(A_FLAG, d); chk("R5 both: fall", d, 32'h0020);
  endtask

  task automatic t_port_sel();
    logic [31:0] d;
    quiesce();
    bus_wr(A_SHI, 32'h0000_0640);   // line 9 -> port 4, line 10 -> port 6 (unmapped)
    bus_wr(A_RISE, 32'h0600);
    pin(0, 9, 1'b1); tick(4);
    bus_rd(A_FLAG, d); chk("R3 other port ignored", d, 0);
    pin(4, 9, 1'b1); tick(4);
    bus_rd(A_FLAG, d); chk("R3 selected port 4", d, 32'h0200);
    for (int p = 0; p < NP; p++) pin(p, 10, 1'b1);
    tick(4);
    bus_rd(A_FLAG, d); chk("R3 unmapped select constant 0", d, 32'h0200);
    quiesce();
    for (int p = 0; p < NP; p++) begin pin(p, 9, 1'b0); pin(p, 10, 1'b0); end
    bus_wr(A_SHI, 0);
    tick(4);
  endtask

  task automatic t_sel_change();
    logic [31:0] d;
    quiesce();
    pin(1, 2, 1'b1); tick(4);
    bus_wr(A_RISE, 32'h0004); bus_wr(A_FALL, 32'h0004);
    bus_wr(A_SLO, 32'h0000_0100);   // line 2 -> port 1
    tick(5);
    bus_rd(A_FLAG, d); chk("R10 select change no flag", d, 0);
    pin(1, 2, 1'b0); tick(4);
    bus_rd(A_FLAG, d); chk("R10 new pin tracked", d, 32'h0004);
    quiesce();
    bus_wr(A_SLO, 0); tick(4);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    quiesce();
    bus_wr(A_RISE, 32'h0010);
    pin(0, 4, 1'b1); tick(4);
    pin(0, 4, 1'b0); tick(4);
    bus_rd(A_FLAG, d); chk("R8 precondition flag", d, 32'h0010);
    pin(0, 4, 1'b1);
    tick(2);
    bus_wr(A_CLR, 32'h0010);        // lands on the detection edge
    bus_rd(A_FLAG, d); chk("R8 edge wins over clear", d, 32'h0010);
    bus_wr(A_CLR, 32'h0010);
    bus_rd(A_FLAG, d); chk("R7 later clear", d, 0);
    pin(0, 4, 1'b0); tick(4);
  endtask

  task automatic t_parity();
    logic [31:0] d;
    quiesce();
    bus_wr(A_RISE, 32'h00C0); bus_wr(A_IEN, 32'hFFFF);
    pin(0, 7, 1'b1); tick(4);
    chk("R9 odd only", {30'd0, irq_odd_o, irq_even_o}, 32'h2);
    pin(0, 6, 1'b1); tick(4);
    chk("R9 both", {30'd0, irq_odd_o, irq_even_o}, 32'h3);
    bus_wr(A_CLR, 32'h0080);
    chk("R9 even only", {30'd0, irq_odd_o, irq_even_o}, 32'h1);
    bus_wr(A_IEN, 32'hFFBF);
    bus_rd(A_FLAG, d); chk("R6 masked flag kept", d, 32'h0040);
    chk("R6 masked no irq", {30'd0, irq_odd_o, irq_even_o}, 0);
    quiesce();
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    t_reset();
    t_regmap();
    t_rise();
    t_fall_both();
    t_port_sel();
    t_sel_change();
    t_set_wins();
    t_parity();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule